// File: doc/BRIEF.md
# Exception Priority Resolver and Vector Generator

This block decides which exception a processor core should take next. It gathers pending requests from a restart line, two system exceptions with fixed priority (the non-maskable interrupt and the hard fault), six system exceptions with configurable priority, and a parameterised number of peripheral interrupts. From the sources that are pending and enabled, it picks the single most urgent one. It then reports that source's exception number, its signed interrupt number and the address of its entry in the vector table.

Software uses a small write port to enable or disable sources, to set their priorities and to raise pending bits. The core clears a pending bit by presenting the number of the exception it has accepted on the acknowledge inputs. The decision is registered. It reflects the inputs of a cycle at the next clock edge.

Top module: `exc_prio_resolver`

## Requirements
- R1: While `rst_n` is low at a clock edge, every pending bit, every configurable enable and every configurable priority is cleared, and the outputs read `sel_valid`=0, `sel_exc_num`=0, `sel_irq_num`=0 and `sel_vector`=0.
- R2: While `restart_req` is high, the next edge reports exception 1, vector 0x04 and interrupt number -15, ahead of every other source. It needs no enable and is never acknowledged.
- R3: A pulse on `nmi_req`, or a pending write to number 2, makes exception 2 pending. Enable writes to number 2 have no effect. It outranks every source except the restart.
- R4: Exception 3 (hard fault) outranks every configurable source, whatever their priority values are. It needs no enable.
- R5: The configurable sources are numbers 4, 5, 6, 11, 14 and 15 (`sys_req` bits 0 to 5 in that order) and numbers 16+k (`irq_req[k]`). Each has a 3-bit priority, and a lower value wins.
- R6: When two pending, enabled configurable sources have equal priority, the lower exception number wins.
- R7: A pending source that is disabled is not selected. Its pending bit is kept, so it is selected once it is enabled.
- R8: Numbers 7 to 10 and 12 to 13 are never reported, and writes of any kind that target them change nothing.
- R9: `sel_irq_num` equals the exception number minus 16 (signed), and `sel_vector` equals the exception number times 4.
- R10: A write with `wr_en` high acts on the source named by `wr_num`, according to `wr_kind`. 2'b00 loads the enable from `wr_data[0]`. 2'b01 loads the priority from `wr_data`. 2'b10 sets the pending bit. 2'b11 does nothing.
- R11: `ack_valid` with `ack_num` clears that source's pending bit at the next edge. A new request or pending write to the same source in the same cycle keeps it pending.
- R12: Requests, writes and acknowledges presented in a cycle change the outputs at the next clock edge and not before.
- R13: With nothing pending and enabled, `sel_valid` is 0 and `sel_exc_num` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart_req | input | 1 | Restart request (level) |
| nmi_req | input | 1 | Non-maskable interrupt request pulse |
| hardfault_req | input | 1 | Hard fault request pulse |
| sys_req | input | 6 | Configurable system exception request pulses (numbers 4,5,6,11,14,15) |
| irq_req | input | NUM_IRQ | Peripheral interrupt request pulses |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Write kind: enable, priority, pend, none |
| wr_num | input | NUM_W | Exception number targeted by the write |
| wr_data | input | PRIO_W | Write data (bit 0 is the enable value) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_num | input | NUM_W | Exception number being acknowledged |
| sel_valid | output | 1 | A source is selected |
| sel_exc_num | output | NUM_W | Selected exception number |
| sel_irq_num | output | NUM_W+1 | Selected signed interrupt number |
| sel_vector | output | NUM_W+2 | Selected vector table address |

## Verification
Clearing a pending bit by acknowledge and setting it again by a fresh request can land on the same source in the same cycle. The bench provokes this by pulsing `irq_req[0]` in the very cycle that acknowledges exception 16. It judges the outcome at the next edge, where exception 16 must still be selected. A further acknowledge alone must then leave the block idle. In the same way, a new hard fault is raised together with a configurable interrupt in one cycle, and only the hard fault may be reported.

// File: rtl/exc_pkg.sv
// Package: shared constants, write-kind encoding and slot-to-number mapping
// for the exception priority resolver. Assumes slots are ordered by ascending
// exception number so that a first-found scan resolves ties toward lower numbers.
package exc_pkg;
    localparam int NUM_FIXED   = 2;   // NMI and hard fault slots
    localparam int NUM_SYS_CFG = 6;   // configurable system exceptions
    localparam int EXC_RESTART = 1;
    localparam int EXC_NMI     = 2;
    localparam int EXC_HARD    = 3;
    localparam int FIRST_IRQ   = 16;

    typedef enum logic [1:0] {
        WR_ENABLE = 2'b00,
        WR_PRIO   = 2'b01,
        WR_PEND   = 2'b10,
        WR_NONE   = 2'b11
    } wr_kind_e;

    // Map a slot index to its exception number.
    function automatic int slot_num(input int s);
        if (s == 0) return EXC_NMI;
        if (s == 1) return EXC_HARD;
        case (s)
            2:       return 4;
            3:       return 5;
            4:       return 6;
            5:       return 11;
            6:       return 14;
            7:       return 15;
            default: return FIRST_IRQ + s - (NUM_FIXED + NUM_SYS_CFG);
        endcase
    endfunction
endpackage

// File: rtl/exc_src_regs.sv
// Per-source state: pending bits for all slots, plus enable and priority for
// configurable slots. Presents next-state values so that the selection can be
// registered in the same edge. Assumes request inputs are single-cycle pulses.
module exc_src_regs
    import exc_pkg::*;
#(
    parameter int NSLOT  = 16,
    parameter int PRIO_W = 3,
    parameter int NUM_W  = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSLOT-1:0]             req,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_kind,
    input  logic [NUM_W-1:0]             wr_num,
    input  logic [PRIO_W-1:0]            wr_data,
    input  logic                         ack_valid,
    input  logic [NUM_W-1:0]             ack_num,
    output logic [NSLOT-1:0]             pend_nxt,
    output logic [NSLOT-1:0]             en_nxt,
    output logic [NSLOT-1:0][PRIO_W-1:0] prio_nxt
);
    logic [NSLOT-1:0] pend_q;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam logic [NUM_W-1:0] SNUM = NUM_W'(slot_num(s));
        logic hit_wr;
        logic hit_ack;

        // Decode whether this cycle's write or acknowledge targets this slot.
        always_comb begin
            hit_wr  = wr_en && (wr_num == SNUM);
            hit_ack = ack_valid && (ack_num == SNUM);
        end

        // Next pending: a new request or pend write wins over an acknowledge.
        always_comb begin
            pend_nxt[s] = req[s] || (hit_wr && wr_kind == WR_PEND) ||
                          (pend_q[s] && !hit_ack);
        end

        if (s < NUM_FIXED) begin : g_fixed
            // Fixed-priority sources are always enabled; priority is unused.
            always_comb begin
                en_nxt[s]   = 1'b1;
                prio_nxt[s] = '0;
            end
        end else begin : g_cfg
            logic              en_q;
            logic [PRIO_W-1:0] prio_q;

            // Next enable and priority from the write port.
            always_comb begin
                en_nxt[s]   = (hit_wr && wr_kind == WR_ENABLE) ? wr_data[0] : en_q;
                prio_nxt[s] = (hit_wr && wr_kind == WR_PRIO) ? wr_data : prio_q;
            end

            // Store enable and priority; cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_q   <= 1'b0;
                    prio_q <= '0;
                end else begin
                    en_q   <= en_nxt[s];
                    prio_q <= prio_nxt[s];
                end
            end
        end

        // An acknowledge with no coinciding set clears the pending bit.
        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_ack && !req[s] && !(hit_wr && wr_kind == WR_PEND)) |=> !pend_q[s]); // R11
    end

    // Store pending bits; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_nxt;
    end
endmodule

// File: rtl/exc_pick.sv
// Combinational arbiter: ranks every pending, enabled slot and returns the
// winner's exception number. Fixed slots rank 0 and 1, configurable slots rank
// priority+2. Assumes slots are in ascending number order (ties to lower number).
module exc_pick
    import exc_pkg::*;
#(
    parameter int NSLOT  = 16,
    parameter int PRIO_W = 3,
    parameter int NUM_W  = 5
) (
    input  logic                         restart,
    input  logic [NSLOT-1:0]             pend,
    input  logic [NSLOT-1:0]             en,
    input  logic [NSLOT-1:0][PRIO_W-1:0] prio,
    output logic                         pick_valid,
    output logic [NUM_W-1:0]             pick_num
);
    localparam int RANK_W = PRIO_W + 1;

    logic [RANK_W-1:0] best_rank;
    logic [RANK_W-1:0] cand_rank;
    logic              found;

    // Linear scan keeping the strictly better candidate; restart overrides.
    always_comb begin
        found     = 1'b0;
        best_rank = '1;
        pick_num  = '0;
        cand_rank = '0;
        for (int s = 0; s < NSLOT; s++) begin
            cand_rank = (s < NUM_FIXED) ? RANK_W'(s)
                                        : RANK_W'(prio[s]) + RANK_W'(NUM_FIXED);
            if (pend[s] && en[s] && (!found || cand_rank < best_rank)) begin
                found     = 1'b1;
                best_rank = cand_rank;
                pick_num  = NUM_W'(slot_num(s));
            end
        end
        if (restart) begin
            found    = 1'b1;
            pick_num = NUM_W'(EXC_RESTART);
        end
        pick_valid = found;
    end
endmodule

// File: rtl/exc_vec_out.sv
// Output register: holds the selected number and derives the signed interrupt
// number and vector address from it. Assumes pick_num is 0 when not valid.
module exc_vec_out #(
    parameter int NUM_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pick_valid,
    input  logic [NUM_W-1:0]        pick_num,
    output logic                    sel_valid,
    output logic [NUM_W-1:0]        sel_exc_num,
    output logic signed [NUM_W:0]   sel_irq_num,
    output logic [NUM_W+1:0]        sel_vector
);
    logic [NUM_W:0] num_ext;

    // Register the decision; reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid   <= 1'b0;
            sel_exc_num <= '0;
        end else begin
            sel_valid   <= pick_valid;
            sel_exc_num <= pick_valid ? pick_num : '0;
        end
    end

    // Derive the signed interrupt number and the vector address.
    always_comb begin
        num_ext     = {1'b0, sel_exc_num};
        sel_irq_num = sel_valid ? $signed(num_ext - (NUM_W+1)'(16)) : '0;
        sel_vector  = {sel_exc_num, 2'b00};
    end
endmodule

// File: rtl/exc_prio_resolver.sv
// Top: exception priority resolver and vector generator. Collects requests,
// holds per-source state, picks the most urgent pending, enabled source and
// registers its number, signed interrupt number and vector address.
// Assumes synchronous active-low reset and single-cycle request pulses.
module exc_prio_resolver
    import exc_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3,
    localparam int NUM_W  = $clog2(FIRST_IRQ + NUM_IRQ),
    localparam int NSLOT  = NUM_FIXED + NUM_SYS_CFG + NUM_IRQ
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  restart_req,
    input  logic                  nmi_req,
    input  logic                  hardfault_req,
    input  logic [5:0]            sys_req,
    input  logic [NUM_IRQ-1:0]    irq_req,
    input  logic                  wr_en,
    input  logic [1:0]            wr_kind,
    input  logic [NUM_W-1:0]      wr_num,
    input  logic [PRIO_W-1:0]     wr_data,
    input  logic                  ack_valid,
    input  logic [NUM_W-1:0]      ack_num,
    output logic                  sel_valid,
    output logic [NUM_W-1:0]      sel_exc_num,
    output logic signed [NUM_W:0] sel_irq_num,
    output logic [NUM_W+1:0]      sel_vector
);
    logic [NSLOT-1:0]             req_all;
    logic [NSLOT-1:0]             pend_nxt;
    logic [NSLOT-1:0]             en_nxt;
    logic [NSLOT-1:0][PRIO_W-1:0] prio_nxt;
    logic                         pick_valid;
    logic [NUM_W-1:0]             pick_num;

    // Gather request pulses in slot order.
    always_comb req_all = {irq_req, sys_req, hardfault_req, nmi_req};

    exc_src_regs #(.NSLOT(NSLOT), .PRIO_W(PRIO_W), .NUM_W(NUM_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .req(req_all),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_num(wr_num), .wr_data(wr_data),
        .ack_valid(ack_valid), .ack_num(ack_num),
        .pend_nxt(pend_nxt), .en_nxt(en_nxt), .prio_nxt(prio_nxt)
    );

    exc_pick #(.NSLOT(NSLOT), .PRIO_W(PRIO_W), .NUM_W(NUM_W)) u_pick (
        .restart(restart_req), .pend(pend_nxt), .en(en_nxt), .prio(prio_nxt),
        .pick_valid(pick_valid), .pick_num(pick_num)
    );

    exc_vec_out #(.NUM_W(NUM_W)) u_out (
        .clk(clk), .rst_n(rst_n), .pick_valid(pick_valid), .pick_num(pick_num),
        .sel_valid(sel_valid), .sel_exc_num(sel_exc_num),
        .sel_irq_num(sel_irq_num), .sel_vector(sel_vector)
    );

    AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> (sel_valid && sel_exc_num == NUM_W'(EXC_RESTART))); // R2
    AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !restart_req) |=> (sel_valid && sel_exc_num == NUM_W'(EXC_NMI))); // R3
    AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> !(sel_exc_num inside {7, 8, 9, 10, 12, 13})); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> (sel_exc_num == '0 && sel_vector == '0 && sel_irq_num == '0)); // R13
endmodule

// File: tb/exc_prio_resolver_bench.sv
module exc_prio_resolver_bench;
    localparam int NUM_IRQ = 8;
    localparam int PRIO_W  = 3;
    localparam int NUM_W   = 5;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  restart_req = 1'b0;
    logic                  nmi_req = 1'b0;
    logic                  hardfault_req = 1'b0;
    logic [5:0]            sys_req = '0;
    logic [NUM_IRQ-1:0]    irq_req = '0;
    logic                  wr_en = 1'b0;
    logic [1:0]            wr_kind = '0;
    logic [NUM_W-1:0]      wr_num = '0;
    logic [PRIO_W-1:0]     wr_data = '0;
    logic                  ack_valid = 1'b0;
    logic [NUM_W-1:0]      ack_num = '0;
    logic                  sel_valid;
    logic [NUM_W-1:0]      sel_exc_num;
    logic signed [NUM_W:0] sel_irq_num;
    logic [NUM_W+1:0]      sel_vector;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    exc_prio_resolver #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_exc_prio_resolver (
        .clk(clk), .rst_n(rst_n), .restart_req(restart_req), .nmi_req(nmi_req),
        .hardfault_req(hardfault_req), .sys_req(sys_req), .irq_req(irq_req),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_num(wr_num), .wr_data(wr_data),
        .ack_valid(ack_valid), .ack_num(ack_num), .sel_valid(sel_valid),
        .sel_exc_num(sel_exc_num), .sel_irq_num(sel_irq_num), .sel_vector(sel_vector)
    );

    always #5 clk = ~clk;

    // Compare all outputs against the expected selection.
    task automatic chk(input string req, input bit ev, input int en_num);
        int exp_irq;
        int exp_vec;
        exp_irq = ev ? en_num - 16 : 0;
        exp_vec = ev ? en_num * 4 : 0;
        n_tests++;
        if (sel_valid !== ev || int'(sel_exc_num) != (ev ? en_num : 0) ||
            int'(sel_irq_num) != exp_irq || int'(sel_vector) != exp_vec) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b num=%0d irq=%0d vec=0x%0h, expected valid=%0b num=%0d irq=%0d vec=0x%0h",
                     req, sel_valid, sel_exc_num, int'(sel_irq_num), sel_vector,
                     ev, ev ? en_num : 0, exp_irq, exp_vec);
        end
    endtask

    task automatic wr(input logic [1:0] k, input int num, input int data);
        wr_en = 1'b1; wr_kind = k; wr_num = NUM_W'(num); wr_data = PRIO_W'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input bit n, input bit h, input logic [5:0] s, input logic [NUM_IRQ-1:0] q);
        nmi_req = n; hardfault_req = h; sys_req = s; irq_req = q;
        @(negedge clk);
        nmi_req = 1'b0; hardfault_req = 1'b0; sys_req = '0; irq_req = '0;
    endtask

    task automatic ack(input int num, input logic [NUM_IRQ-1:0] q);
        ack_valid = 1'b1; ack_num = NUM_W'(num); irq_req = q;
        @(negedge clk);
        ack_valid = 1'b0; irq_req = '0;
    endtask

    task automatic t_reset_state();
        chk("R1 reset", 1'b0, 0);
    endtask

    task automatic t_disabled_pending();
        pulse(0, 0, '0, 8'h01);
        chk("R7 disabled ignored", 1'b0, 0);
        wr(2'b00, 16, 1);
        chk("R7 R9 kept then enabled", 1'b1, 16);
    endtask

    task automatic t_priority_order();
        wr(2'b01, 17, 1);
        wr(2'b00, 17, 1);
        pulse(0, 0, '0, 8'h02);
        chk("R5 lower value wins", 1'b1, 16);
        wr(2'b01, 16, 5);
        chk("R5 after priority change", 1'b1, 17);
        ack(17, '0);
        chk("R11 ack clears", 1'b1, 16);
        ack(16, '0);
        chk("R13 idle", 1'b0, 0);
    endtask

    task automatic t_tie_break();
        wr(2'b00, 15, 1);
        wr(2'b01, 15, 2);
        wr(2'b01, 18, 2);
        wr(2'b00, 18, 1);
        pulse(0, 0, 6'b100000, 8'h04);
        chk("R6 tie to lower number", 1'b1, 15);
        ack(15, '0);
        chk("R6 R9 next in line", 1'b1, 18);
        ack(18, '0);
        chk("R13 idle after tie", 1'b0, 0);
    endtask

    task automatic t_hardfault();
        wr(2'b01, 16, 0);
        pulse(0, 1, '0, 8'h01);
        chk("R4 hard fault over prio 0", 1'b1, 3);
        ack(3, '0);
        chk("R4 back to irq", 1'b1, 16);
    endtask

    task automatic t_nmi();
        wr(2'b00, 2, 0);
        pulse(1, 0, '0, '0);
        chk("R3 NMI not disableable", 1'b1, 2);
        ack(2, '0);
        chk("R3 after NMI ack", 1'b1, 16);
    endtask

    task automatic t_restart();
        restart_req = 1'b1;
        @(negedge clk);
        chk("R2 restart", 1'b1, 1);
        restart_req = 1'b0;
        @(negedge clk);
        chk("R2 restart released", 1'b1, 16);
    endtask

    task automatic t_reserved();
        wr(2'b00, 7, 1);
        wr(2'b01, 7, 0);
        wr(2'b10, 7, 0);
        wr(2'b10, 12, 0);
        chk("R8 reserved writes", 1'b1, 16);
        ack(16, '0);
        wr(2'b10, 10, 0);
        chk("R8 reserved pend", 1'b0, 0);
    endtask

    task automatic t_write_kinds();
        wr(2'b11, 17, 1);
        chk("R10 kind 3 no effect", 1'b0, 0);
        wr(2'b10, 17, 0);
        chk("R10 software pend", 1'b1, 17);
        ack(17, '0);
        chk("R10 cleared", 1'b0, 0);
    endtask

    task automatic t_ack_and_set();
        pulse(0, 0, '0, 8'h01);
        chk("R11 pend", 1'b1, 16);
        ack(16, 8'h01);
        chk("R11 set beats ack", 1'b1, 16);
        ack(16, '0);
        chk("R11 final ack", 1'b0, 0);
    endtask

    task automatic t_timing();
        irq_req = 8'h01;
        #2;
        chk("R12 no change before edge", 1'b0, 0);
        @(negedge clk);
        irq_req = '0;
        chk("R12 change at edge", 1'b1, 16);
        ack(16, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_disabled_pending();
        t_priority_order();
        t_tie_break();
        t_hardfault();
        t_nmi();
        t_restart();
        t_reserved();
        t_write_kinds();
        t_ack_and_set();
        t_timing();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule